// File: doc/BRIEF.md
# Dual Interval Timer With Status Port

This block provides two 8-bit interval timers for an FM sound generator, reached by a host through a two-location byte port. The host first writes a register index at location 0, then writes the value at location 1. A read at location 0 returns a status byte. Timer 1 counts in base ticks of 80 µs and timer 2 in base ticks of 320 µs. Each tick period is set by a prescaler whose divide ratio is computed from the system clock frequency parameter.

A running timer counts up from its preset. When it passes 0xFF it overflows, reloads the preset and keeps counting. An unmasked overflow latches that timer's flag. A summary bit, and an active-low interrupt output, show whether either flag is set. One control register sets the run and mask bits for both timers and issues the flag-clear command. The reset input is asynchronous and active-low, and the block releases it in step with the clock.

Top module: `fm_dual_timer`

## Requirements
- R1: After reset the status byte reads 0x00, `irq_n` is 1 and both timers are stopped.
- R2: A write with `host_sel`=0 stores the register index. A write with `host_sel`=1 writes the indexed register: 0x02 is the timer 1 preset, 0x03 is the timer 2 preset and 0x04 is control. Data written to any other index changes nothing.
- R3: Timer 1 counts base ticks of 80 µs (`CLK_HZ`/1000*80/1000 clocks). Started with preset P, it first overflows after 256−P ticks, so preset 0xFF overflows after one tick.
- R4: Timer 2 behaves the same way with base ticks of 320 µs (`CLK_HZ`/1000*320/1000 clocks).
- R5: With `host_sel`=0, `host_dout` gives the status byte: bit 7 is the summary (flag 1 OR flag 2), bit 6 is the timer 1 flag, bit 5 is the timer 2 flag and bits 4..0 are 0. With `host_sel`=1, `host_dout` is 0x00.
- R6: In the control register, bit 6 masks timer 1 and bit 5 masks timer 2. A masked timer may keep counting, but it never sets its flag.
- R7: A control write with bit 7 set clears all flags at that write's clock edge. The other bits of that write are ignored, so run and mask states do not change.
- R8: Control bit 0 runs timer 1 and bit 1 runs timer 2. Writing 0x60 (both masks set, both run bits clear) stops both timers, and no flag is set after that.
- R9: After an overflow the counter reloads its preset and keeps running, so overflows repeat every 256−P ticks.
- R10: `irq_n` is the inverse of the status summary bit.
- R11: When a run bit goes from 0 to 1, that timer reloads its preset and restarts its prescaler, whatever count it held when it was stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one clock per write |
| host_sel | input | 1 | Port location: 0 = index/status, 1 = data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Status byte at location 0, zero at location 1 |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
A wrong prescaler or counter state shows up as a status flag that rises early or late. The error appears within one overflow period of the timer, which is 256−P base ticks. A wrong run or start state shows as a restarted timer that overflows on the old residual count instead of after 256−P ticks. A wrong mask or clear state shows as a flag that appears, or stays set, at the next overflow. The bench runs a behavioural model of tick and overflow timing and compares `host_dout` and `irq_n` against it on every clock, so any of these faults is caught in the cycle it first reaches a port. To keep run times short, the bench uses a scaled clock-frequency parameter.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;
  localparam int unsigned NTMR    = 2;
  localparam int unsigned DW      = 8;
  localparam logic [7:0]  IDX_PRE1 = 8'h02;
  localparam logic [7:0]  IDX_PRE2 = 8'h03;
  localparam logic [7:0]  IDX_CTRL = 8'h04;
  // control bit positions
  localparam int unsigned CB_CLR   = 7;
  localparam int unsigned CB_MASK1 = 6;   // timer i mask sits at CB_MASK1 - i
  localparam int unsigned CB_RUN1  = 0;   // timer i run sits at CB_RUN1 + i

  typedef struct packed {
    logic [NTMR-1:0] run;
    logic [NTMR-1:0] mask;
  } tmr_ctrl_t;
endpackage

// File: rtl/fm_host_regs.sv
module fm_host_regs
  import fm_timer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      sel,
  input  logic [DW-1:0]             din,
  output logic [NTMR-1:0][DW-1:0]   preset_o,
  output tmr_ctrl_t                 ctrl_o,
  output logic [NTMR-1:0]           start_o,
  output logic                      clr_o
);
  logic [DW-1:0]           idx_q, idx_d;
  logic [NTMR-1:0][DW-1:0] pre_q, pre_d;
  tmr_ctrl_t               ctl_q, ctl_d;
  logic [NTMR-1:0]         start_q, start_d;
  logic                    data_wr;

  assign data_wr = we & sel;
  assign clr_o   = data_wr & (idx_q == IDX_CTRL) & din[CB_CLR];

  always_comb begin
    idx_d   = idx_q;
    pre_d   = pre_q;
    ctl_d   = ctl_q;
    start_d = '0;
    if (we && !sel) idx_d = din;
    if (data_wr) begin
      case (idx_q)
        IDX_PRE1: pre_d[0] = din;
        IDX_PRE2: pre_d[1] = din;
        IDX_CTRL: begin
          if (!din[CB_CLR]) begin
            for (int i = 0; i < NTMR; i++) begin
              ctl_d.run[i]  = din[CB_RUN1 + i];
              ctl_d.mask[i] = din[CB_MASK1 - i];
              start_d[i]    = din[CB_RUN1 + i] & ~ctl_q.run[i];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      pre_q   <= '0;
      ctl_q   <= '0;
      start_q <= '0;
    end else begin
      idx_q   <= idx_d;
      pre_q   <= pre_d;
      ctl_q   <= ctl_d;
      start_q <= start_d;
    end
  end

  assign preset_o = pre_q;
  assign ctrl_o   = ctl_q;
  assign start_o  = start_q;
endmodule

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int unsigned DIV = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run & ~restart & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)    cnt_d = '0;
    else if (run)   cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fm_ivl_counter.sv
module fm_ivl_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] preset,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = &cnt_q;
  assign ovf  = tick & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = preset;
    else if (tick) cnt_d = wrap ? preset : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fm_flag_unit.sv
module fm_flag_unit #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q, flg_d;

  always_comb begin
    if (clr) flg_d = '0;
    else     flg_d = flg_q | (ovf & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/fm_dual_timer.sv
module fm_dual_timer
  import fm_timer_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned T1_US  = 80,
  parameter int unsigned T2_US  = 320
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_we,
  input  logic         host_sel,
  input  logic [7:0]   host_din,
  output logic [7:0]   host_dout,
  output logic         irq_n
);
  localparam int unsigned DIV1 = (CLK_HZ / 1000) * T1_US / 1000;
  localparam int unsigned DIV2 = (CLK_HZ / 1000) * T2_US / 1000;

  logic [1:0]              rsync_q;
  logic                    srst_n;
  logic [NTMR-1:0][DW-1:0] preset;
  tmr_ctrl_t               ctrl;
  logic [NTMR-1:0]         start;
  logic                    clr;
  logic [NTMR-1:0]         tick;
  logic [NTMR-1:0]         ovf;
  logic [NTMR-1:0]         flags;
  logic                    summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  fm_host_regs u_regs (
    .clk(clk), .rst_n(srst_n), .we(host_we), .sel(host_sel), .din(host_din),
    .preset_o(preset), .ctrl_o(ctrl), .start_o(start), .clr_o(clr)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int unsigned DIV_G = (g == 0) ? DIV1 : DIV2;
    fm_tick_gen #(.DIV(DIV_G)) u_tick (
      .clk(clk), .rst_n(srst_n), .run(ctrl.run[g]), .restart(start[g]),
      .tick(tick[g])
    );
    fm_ivl_counter #(.W(DW)) u_cnt (
      .clk(clk), .rst_n(srst_n), .restart(start[g]), .tick(tick[g]),
      .preset(preset[g]), .ovf(ovf[g])
    );
  end

  fm_flag_unit #(.N(NTMR)) u_flags (
    .clk(clk), .rst_n(srst_n), .ovf(ovf), .mask(ctrl.mask), .clr(clr),
    .flags(flags)
  );

  assign summary   = |flags;
  assign host_dout = host_sel ? 8'h00 : {summary, flags[0], flags[1], 5'b0};
  assign irq_n     = ~summary;
endmodule

// File: rtl/fm_dual_timer_chk.sv
module fm_dual_timer_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       host_sel,
  input logic [7:0] host_dout,
  input logic       irq_n,
  input logic [1:0] flags,
  input logic [1:0] mask,
  input logic [1:0] run,
  input logic [1:0] ovf,
  input logic       clr
);
  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !host_sel |-> (irq_n == !host_dout[7]));
  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    host_dout[4:0] == 5'b0);
  // R7
  clear_flags_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clr |=> (flags == 2'b00));
  // R6
  mask1_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!flags[0] && mask[0]) |=> !flags[0]);
  // R6
  mask2_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!flags[1] && mask[1]) |=> !flags[1]);
  // R9
  ovf1_sets_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ovf[0] && !mask[0] && !clr) |=> flags[0]);
  // R8
  stopped_no_ovf_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (run == 2'b00) |-> (ovf == 2'b00));
endmodule

bind fm_dual_timer fm_dual_timer_chk u_chk (
  .clk(clk), .srst_n(srst_n), .host_sel(host_sel), .host_dout(host_dout),
  .irq_n(irq_n), .flags(flags), .mask(ctrl.mask), .run(ctrl.run),
  .ovf(ovf), .clr(clr)
);

// File: tb/fm_dual_timer_test.sv
module fm_dual_timer_test;
  localparam int CLK_HZ = 100_000;          // scaled: 8 and 32 clocks per tick
  localparam int D1 = (CLK_HZ / 1000) * 80 / 1000;
  localparam int D2 = (CLK_HZ / 1000) * 320 / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  fm_dual_timer #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_din(host_din), .host_dout(host_dout), .irq_n(irq_n)
  );

  // behavioural reference: ticks remaining per timer, counted down
  int m_idx, m_pre[2], m_run[2], m_msk[2], m_arm[2], m_sub[2], m_rem[2], m_flag[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0;
      for (int i = 0; i < 2; i++) begin
        m_pre[i] = 0; m_run[i] = 0; m_msk[i] = 0; m_arm[i] = 0;
        m_sub[i] = 0; m_rem[i] = 256; m_flag[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (m_arm[i] != 0) begin
          m_arm[i] = 0; m_sub[i] = 0; m_rem[i] = 256 - m_pre[i];
        end else if (m_run[i] != 0) begin
          m_sub[i]++;
          if (m_sub[i] == ((i == 0) ? D1 : D2)) begin
            m_sub[i] = 0;
            m_rem[i]--;
            if (m_rem[i] == 0) begin
              m_rem[i] = 256 - m_pre[i];
              if (m_msk[i] == 0) m_flag[i] = 1;
            end
          end
        end
      end
      if (host_we && !host_sel) m_idx = host_din;
      if (host_we && host_sel) begin
        if (m_idx == 2) m_pre[0] = host_din;
        else if (m_idx == 3) m_pre[1] = host_din;
        else if (m_idx == 4) begin
          if (host_din[7]) begin
            m_flag[0] = 0; m_flag[1] = 0;
          end else begin
            for (int i = 0; i < 2; i++) begin
              if (host_din[i] && m_run[i] == 0) m_arm[i] = 1;
              m_run[i] = host_din[i];
              m_msk[i] = host_din[6 - i];
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      automatic logic [7:0] st;
      automatic logic summ = (m_flag[0] != 0) || (m_flag[1] != 0);
      st = host_sel ? 8'h00 : {summ, m_flag[0] != 0, m_flag[1] != 0, 5'b0};
      checks++;
      if (host_dout !== st) begin
        errors++;
        $display("FAIL R5 model status t=%0t got=%h exp=%h", $time, host_dout, st);
      end
      checks++;
      if (irq_n !== !summ) begin
        errors++;
        $display("FAIL R10 model irq t=%0t got=%b exp=%b", $time, irq_n, !summ);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #5;
    host_we = 1'b1; host_sel = sel; host_din = d;
    @(posedge clk); #5;
    host_we = 1'b0; host_sel = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    model_on = 1;
    // R1 reset state
    chk("R1 status after reset", host_dout, 8'h00);
    chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    // R5 data location reads zero
    host_sel = 1'b1; cyc(1);
    chk("R5 data location read", host_dout, 8'h00);
    host_sel = 1'b0; cyc(1);
    // R2 unknown index ignored
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h07, 8'h01);
    cyc(40);
    chk("R2 ignored index", host_dout, 8'h00);
    // R3 R6 timer1 preset FF, timer2 masked
    reg_wr(8'h04, 8'h21);
    cyc(5);
    chk("R3 before first tick", host_dout, 8'h00);
    cyc(7);
    chk("R3 R6 one-tick overflow", host_dout, 8'hC0);
    chk("R10 irq asserted", {7'b0, irq_n}, 8'h00);
    // R7 clear, other bits ignored; R9 reload and keep running
    reg_wr(8'h04, 8'h80);
    cyc(1);
    chk("R7 cleared", host_dout, 8'h00);
    cyc(12);
    chk("R7 R9 still running after clear", host_dout, 8'hC0);
    // R8 stop both
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);
    cyc(100);
    chk("R8 stopped", host_dout, 8'h00);
    // R4 timer2 preset FE (2 ticks)
    reg_wr(8'h03, 8'hFE);
    reg_wr(8'h04, 8'h42);
    cyc(50);
    chk("R4 before two ticks", host_dout, 8'h00);
    cyc(20);
    chk("R4 timer2 overflow", host_dout, 8'hA0);
    // R11 restart reloads preset
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);
    reg_wr(8'h02, 8'hF0);
    reg_wr(8'h04, 8'h21);
    cyc(60);
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h02, 8'hFC);
    reg_wr(8'h04, 8'h21);
    cyc(30);
    chk("R11 before reloaded count", host_dout, 8'h00);
    cyc(8);
    chk("R11 overflow after reload", host_dout, 8'hC0);
    // R6 both masked while running
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);
    reg_wr(8'h02, 8'hFF);
    reg_wr(8'h03, 8'hFF);
    reg_wr(8'h04, 8'h63);
    cyc(100);
    chk("R6 masked timers", host_dout, 8'h00);
    // R5 both flags
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h03);
    cyc(40);
    chk("R5 both flags", host_dout, 8'hE0);
    reg_wr(8'h04, 8'h60);
    cyc(4);
    finish_run();
  end
endmodule